// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two two's complement integers over several clock cycles using radix-2 Booth recoding. A single adder/subtractor, one bit wider than the operands, works on the upper half of a combined product/multiplier register. A shadow bit sits to the right of that register. On each step, the multiplier bit in the register's least significant position and the shadow bit to its right decide whether the multiplicand is subtracted, added, or left out. The whole register, together with the shadow bit, then shifts right one place with sign extension. After `WIDTH` steps the register holds the signed product, which is presented as a high word and a low word.

Operands enter through a valid/ready handshake. `in_ready` is high whenever no multiplication is in progress, and a transfer happens on a rising edge where `in_valid` and `in_ready` are both high. While the block is busy, `in_ready` stays low and any offered operands are held off. The result side has no back-pressure: `out_valid` is a single-cycle pulse and cannot be stalled. The product stays on `prod_hi`/`prod_lo` until the next transfer is accepted, so a consumer that misses the pulse can still read the value afterwards.

Top module: `booth_mult`

## Requirements
- R1: While `rst_n` is low and after it is released, `in_ready` is 1, `out_valid` is 0, and `prod_hi` and `prod_lo` are 0.
- R2: Operands are captured on the rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the cycle in which `out_valid` is high.
- R3: `in_valid` asserted while the block is busy is ignored. The result equals the product of the originally accepted operands, and the latency is unchanged.
- R4: `out_valid` is high for exactly one cycle. It becomes high after the `WIDTH`-th rising edge following the accepting edge, which is one step per clock.
- R5: `{prod_hi, prod_lo}` equals the signed product of `in_mcand` and `in_mplier` taken as `2*WIDTH`-bit two's complement. `prod_hi` is the upper `WIDTH` bits.
- R6: The result is correct when either or both operands are the most negative value, -2^(WIDTH-1), including the case where both are.
- R7: Each step looks at the pair formed by the current multiplier bit and the bit to its right. Pair 10 subtracts the multiplicand from the upper half. Pair 01 adds it. Pairs 00 and 11 leave the upper half unchanged before the shift. The bit to the right of the first step is 0.
- R8: Outside a multiplication, `prod_hi` and `prod_lo` hold their value until the next transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to accept operands |
| in_mcand | input | WIDTH | Multiplicand, two's complement |
| in_mplier | input | WIDTH | Multiplier, two's complement |
| out_valid | output | 1 | One-cycle pulse: product is ready |
| prod_hi | output | WIDTH | Upper half of the signed product |
| prod_lo | output | WIDTH | Lower half of the signed product |

## Verification
The bench builds two instances, one at the default `WIDTH` of 32 and one at `WIDTH` 4. The 4-bit instance makes an exhaustive sweep of all 256 operand pairs affordable. That sweep covers every Booth pair sequence and both extreme values, including the short examples 2×7 and 2×(-3). The 32-bit instance takes directed corner operands: both most-negative, alternating bit patterns that force an add or subtract on every step, all-ones, and zero. It also offers operands while busy, to show that they are refused.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action chosen for one Booth step
  typedef enum logic [1:0] {
    BOOTH_KEEP = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_op_e;

  // Radix-2 recoding of (current bit, bit to its right)
  function automatic booth_op_e booth_decode(input logic cur, input logic right);
    case ({cur, right})
      2'b10:   return BOOTH_SUB;   // entering a run of ones
      2'b01:   return BOOTH_ADD;   // leaving a run of ones
      default: return BOOTH_KEEP;  // inside a run
    endcase
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      right_bit,
  output booth_op_e op
);

  always_comb op = booth_decode(cur_bit, right_bit);

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH:0]   acc,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [WIDTH:0]   result
);

  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] mcand_ext;
  logic [EXT_W-1:0] operand;
  logic             carry_in;

  // One guard bit keeps -2^(WIDTH-1) subtraction exact
  assign mcand_ext = {mcand[WIDTH-1], mcand};

  always_comb begin
    operand  = '0;
    carry_in = 1'b0;
    case (op)
      BOOTH_ADD: operand = mcand_ext;
      BOOTH_SUB: begin
        operand  = ~mcand_ext;
        carry_in = 1'b1;
      end
      default: operand = '0;
    endcase
  end

  assign result = acc + operand + EXT_W'(carry_in);

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic out_valid
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  logic             busy_q;
  logic             done_q;
  logic [CNT_W-1:0] step_q;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign busy      = busy_q;
  assign out_valid = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        if (step_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  // R2
  accept_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  done_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy_q));

endmodule

// File: rtl/booth_mult.sv
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_mcand,
  input  logic [WIDTH-1:0] in_mplier,
  output logic             out_valid,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  localparam int ACC_W = WIDTH + 1;

  logic             accept;
  logic             busy;
  booth_op_e        step_op;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_next;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] low_q;
  logic             shadow_q;

  booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .busy     (busy),
    .out_valid(out_valid)
  );

  booth_recoder u_recode (
    .cur_bit  (low_q[0]),
    .right_bit(shadow_q),
    .op       (step_op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc   (acc_q),
    .mcand (mcand_q),
    .op    (step_op),
    .result(acc_next)
  );

  // Combined register {acc, low, shadow} shifts right arithmetically
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      acc_q    <= '0;
      low_q    <= '0;
      shadow_q <= 1'b0;
    end else if (accept) begin
      mcand_q  <= in_mcand;
      acc_q    <= '0;
      low_q    <= in_mplier;
      shadow_q <= 1'b0;
    end else if (busy) begin
      acc_q    <= {acc_next[ACC_W-1], acc_next[ACC_W-1:1]};
      low_q    <= {acc_next[0], low_q[WIDTH-1:1]};
      shadow_q <= low_q[0];
    end
  end

  assign prod_hi = acc_q[WIDTH-1:0];
  assign prod_lo = low_q;

  // R7
  run_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (low_q[0] == shadow_q)) |-> (acc_next == acc_q));

  // R7
  run_start_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && low_q[0] && !shadow_q) |->
      (acc_next + {mcand_q[WIDTH-1], mcand_q} == acc_q));

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> $stable({prod_hi, prod_lo}));

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

endmodule

// File: tb/test_booth_mult.sv
module test_booth_mult;

  localparam int W32 = 32;
  localparam int W4  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           v32 = 1'b0, r32, o32;
  logic [W32-1:0] a32 = '0, b32 = '0, hi32, lo32;
  logic           v4 = 1'b0, r4, o4;
  logic [W4-1:0]  a4 = '0, b4 = '0, hi4, lo4;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  booth_mult #(.WIDTH(W32)) i_booth_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_ready(r32),
    .in_mcand(a32), .in_mplier(b32), .out_valid(o32),
    .prod_hi(hi32), .prod_lo(lo32));

  booth_mult #(.WIDTH(W4)) i_booth_mult_w4 (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_ready(r4),
    .in_mcand(a4), .in_mplier(b4), .out_valid(o4),
    .prod_hi(hi4), .prod_lo(lo4));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 32-bit multiply with latency, pulse and hold checks (R2 R4 R5 R8)
  task automatic mul32(input logic [W32-1:0] a, input logic [W32-1:0] b,
                       input string req, input bit poke_busy);
    longint exp;
    int n;
    exp = longint'($signed(a)) * longint'($signed(b));
    @(negedge clk);
    check(r32 == 1'b1, "R2 ready before", longint'(r32), 1);
    v32 = 1'b1; a32 = a; b32 = b;
    @(posedge clk);
    @(negedge clk);
    n = 1;
    if (poke_busy) begin
      // R3: offer other operands while busy
      a32 = 32'h1234_5678; b32 = 32'h0000_0003;
      for (int k = 0; k < 10; k++) begin
        check(r32 == 1'b0 && o32 == 1'b0, "R3 ready low while busy", longint'(r32), 0);
        @(negedge clk);
        n++;
      end
    end else begin
      check(r32 == 1'b0, "R2 ready low after accept", longint'(r32), 0);
    end
    v32 = 1'b0;
    while (!o32 && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == W32 + 1, "R4 latency", n, W32 + 1);
    check({hi32, lo32} == 64'(exp), req, longint'({hi32, lo32}), exp);
    @(negedge clk);
    check(o32 == 1'b0, "R4 single pulse", longint'(o32), 0);
    repeat (2) @(negedge clk);
    check({hi32, lo32} == 64'(exp), "R8 hold", longint'({hi32, lo32}), exp);
  endtask

  task automatic mul4(input int a, input int b, input string req);
    int exp;
    int n;
    exp = a * b;
    @(negedge clk);
    v4 = 1'b1; a4 = 4'(a); b4 = 4'(b);
    @(posedge clk);
    @(negedge clk);
    v4 = 1'b0;
    n = 1;
    while (!o4 && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(n == W4 + 1, "R4 latency w4", n, W4 + 1);
    check($signed({hi4, lo4}) == 8'(exp), req, longint'($signed({hi4, lo4})), exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(r32 && !o32 && hi32 == '0 && lo32 == '0, "R1 reset state w32", longint'({r32, o32}), 2);
    check(r4 && !o4 && hi4 == '0 && lo4 == '0, "R1 reset state w4", longint'({r4, o4}), 2);
  endtask

  task automatic test_small();
    mul4(2, 7, "R5 2x7");
    mul4(2, -3, "R5 2x-3");
    mul4(-8, -8, "R6 w4 min x min");
  endtask

  task automatic test_sweep4();
    for (int a = -8; a < 8; a++)
      for (int b = -8; b < 8; b++)
        mul4(a, b, "R7 w4 exhaustive");
  endtask

  task automatic test_corners32();
    mul32(32'd2, 32'd7, "R5 2x7", 1'b0);
    mul32(32'd2, -32'sd3, "R5 2x-3", 1'b0);
    mul32(32'h8000_0000, 32'h8000_0000, "R6 min x min", 1'b0);
    mul32(32'h8000_0000, 32'hFFFF_FFFF, "R6 min x -1", 1'b0);
    mul32(32'h7FFF_FFFF, 32'h8000_0000, "R6 max x min", 1'b0);
    mul32(32'hDEAD_BEEF, 32'h5555_5555, "R7 alternating adds/subs", 1'b0);
    mul32(32'h0001_2345, 32'hAAAA_AAAA, "R7 alternating negative", 1'b0);
    mul32(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 all ones", 1'b0);
    mul32(32'h0000_0000, 32'h7654_3210, "R5 zero", 1'b0);
  endtask

  task automatic test_busy_ignore();
    mul32(32'hFFFF_F00D, 32'h0000_0101, "R3 original operands", 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_small();
    test_sweep4();
    test_corners32();
    test_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule